// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is a sequential multiply and divide engine that owns the two architectural result registers, HI and LO. A caller pulses `start_i` with a six-bit function code and two operands. A product lands as a double-width value across HI:LO. A quotient lands in LO and the matching remainder lands in HI. The same port also carries the moves between the general registers and HI or LO.

Multiply and divide retire one operand bit per cycle. While an operation runs, `busy_o` is high. The surrounding pipeline stalls on it before reading HI or LO, and before issuing any further command. A command presented while `busy_o` is high is not taken, so the caller holds it until `busy_o` falls. A move-to therefore cannot overwrite a result that is still being formed.

Top module: `hilo_mdu`

## Requirements
- R1: After reset, `hi_o` and `lo_o` are zero and `busy_o` is low.
- R2: Function 6'b011000 (signed multiply) treats both operands as two's complement. It places the full double-width product in HI:LO, with the upper half in HI.
- R3: Function 6'b011001 (unsigned multiply) places the double-width unsigned product in HI:LO, with the upper half in HI.
- R4: Function 6'b011010 (signed divide) writes the quotient, truncated toward zero, to LO. It writes the remainder to HI, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 yields LO equal to the most negative value and HI equal to zero.
- R5: Function 6'b011011 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R6: A divide by zero, signed or unsigned, completes normally with LO all ones and HI equal to the raw dividend `rs_i`.
- R7: When a multiply or divide start is taken while idle, `busy_o` is high from the next cycle for exactly WIDTH+1 cycles. The result is in HI and LO when `busy_o` falls.
- R8: When idle, function 6'b010001 loads `rs_i` into HI and function 6'b010011 loads `rs_i` into LO. Each takes effect in one cycle, leaves the other register unchanged and does not raise `busy_o`.
- R9: `mf_data_o` shows HI when `func_i` is 6'b010000 and LO when it is 6'b010010, and zero for any other code. Starting either of these codes changes no state.
- R10: Any start presented while `busy_o` is high is ignored, including move-to and multiply/divide codes. HI and LO hold until the running operation writes its result.
- R11: A start with a function code outside those listed above changes neither HI nor LO and does not raise `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| func_i | input | 6 | Function code |
| rs_i | input | WIDTH | First operand / dividend / move-to source |
| rt_i | input | WIDTH | Second operand / divisor |
| busy_o | output | 1 | Multiply or divide in progress |
| hi_o | output | WIDTH | HI register |
| lo_o | output | WIDTH | LO register |
| mf_data_o | output | WIDTH | Move-from read data selected by `func_i` |

## Verification
The bench uses an 8-bit instance and drives all four arithmetic codes over the cross product of sixteen operand values. The values include zero, one, both sign extremes, all ones and scattered mid-range values. These patterns separate errors in sign correction, the truncation direction, the sign of the remainder, the carry into the upper half and the divide-by-zero override. Every operation is also timed against the fixed busy length. Separate sequences issue moves while idle, issue moves and new starts while busy, and issue an unlisted code, to show which commands may change HI and LO.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam logic [5:0] F_MFHI  = 6'b010000;
  localparam logic [5:0] F_MTHI  = 6'b010001;
  localparam logic [5:0] F_MFLO  = 6'b010010;
  localparam logic [5:0] F_MTLO  = 6'b010011;
  localparam logic [5:0] F_MULT  = 6'b011000;
  localparam logic [5:0] F_MULTU = 6'b011001;
  localparam logic [5:0] F_DIV   = 6'b011010;
  localparam logic [5:0] F_DIVU  = 6'b011011;

  typedef struct packed {
    logic mul;
    logic div;
    logic sgn;
    logic mt_hi;
    logic mt_lo;
  } mdu_cmd_t;
endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
  import mdu_pkg::*;
(
  input  logic [5:0] func_i,
  output mdu_cmd_t   cmd_o
);
  always_comb begin
    cmd_o = '0;
    unique case (func_i)
      F_MULT:  begin cmd_o.mul = 1'b1; cmd_o.sgn = 1'b1; end
      F_MULTU: cmd_o.mul = 1'b1;
      F_DIV:   begin cmd_o.div = 1'b1; cmd_o.sgn = 1'b1; end
      F_DIVU:  cmd_o.div = 1'b1;
      F_MTHI:  cmd_o.mt_hi = 1'b1;
      F_MTLO:  cmd_o.mt_lo = 1'b1;
      default: cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/mdu_mul_seq.sv
// Shift-add multiplier on magnitudes, one multiplier bit per step.
module mdu_mul_seq #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] prod_o
);
  logic [WIDTH-1:0]   mcand_q;
  logic [2*WIDTH-1:0] p_q;
  logic [WIDTH:0]     sum;

  assign sum = {1'b0, p_q[2*WIDTH-1:WIDTH]} + {1'b0, (p_q[0] ? mcand_q : '0)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      p_q     <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      p_q     <= {{WIDTH{1'b0}}, mplier_i};
    end else if (step_i) begin
      p_q <= {sum, p_q[WIDTH-1:1]};
    end
  end

  assign prod_o = p_q;
endmodule

// File: rtl/mdu_div_seq.sv
// Restoring divider on magnitudes, one quotient bit per step.
module mdu_div_seq #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] dvd_i,
  input  logic [WIDTH-1:0] dsr_i,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_o
);
  logic [WIDTH-1:0] rem_q, quo_q, dsr_q;
  logic [WIDTH:0]   sh;
  logic             fits;

  assign sh   = {rem_q, quo_q[WIDTH-1]};
  assign fits = (sh >= {1'b0, dsr_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      quo_q <= dvd_i;
      dsr_q <= dsr_i;
    end else if (step_i) begin
      rem_q <= fits ? (sh[WIDTH-1:0] - dsr_q) : sh[WIDTH-1:0];
      quo_q <= {quo_q[WIDTH-2:0], fits};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/hilo_mdu.sv
module hilo_mdu
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [5:0]       func_i,
  input  logic [WIDTH-1:0] rs_i,
  input  logic [WIDTH-1:0] rt_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o,
  output logic [WIDTH-1:0] mf_data_o
);
  localparam int CW = $clog2(WIDTH + 1);

  mdu_cmd_t cmd;
  logic take, go, step, fin;
  logic neg_a, neg_b;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic [2*WIDTH-1:0] prod, prod_fix;
  logic [WIDTH-1:0] quo, rem, quo_fix, rem_fix;

  logic busy_q, div_q, pneg_q, rneg_q, dz_q;
  logic [CW-1:0] cnt_q;
  logic [WIDTH-1:0] dvd_q, hi_q, lo_q;

  mdu_decode u_dec (.func_i(func_i), .cmd_o(cmd));

  assign take  = start_i & ~busy_q;
  assign go    = take & (cmd.mul | cmd.div);
  assign step  = busy_q & (cnt_q != '0);
  assign fin   = busy_q & (cnt_q == '0);
  assign neg_a = cmd.sgn & rs_i[WIDTH-1];
  assign neg_b = cmd.sgn & rt_i[WIDTH-1];
  assign mag_a = neg_a ? -rs_i : rs_i;
  assign mag_b = neg_b ? -rt_i : rt_i;

  mdu_mul_seq #(.WIDTH(WIDTH)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(go & cmd.mul), .step_i(step & ~div_q),
    .mcand_i(mag_a), .mplier_i(mag_b), .prod_o(prod)
  );

  mdu_div_seq #(.WIDTH(WIDTH)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(go & cmd.div), .step_i(step & div_q),
    .dvd_i(mag_a), .dsr_i(mag_b), .quo_o(quo), .rem_o(rem)
  );

  assign prod_fix = pneg_q ? -prod : prod;
  assign quo_fix  = dz_q ? '1    : (pneg_q ? -quo : quo);
  assign rem_fix  = dz_q ? dvd_q : (rneg_q ? -rem : rem);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
      pneg_q <= 1'b0;
      rneg_q <= 1'b0;
      dz_q   <= 1'b0;
      dvd_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WIDTH);
      div_q  <= cmd.div;
      pneg_q <= neg_a ^ neg_b;
      rneg_q <= neg_a;
      dz_q   <= cmd.div & (rt_i == '0);
      dvd_q  <= rs_i;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (fin) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fin) begin
      hi_q <= div_q ? rem_fix : prod_fix[2*WIDTH-1:WIDTH];
      lo_q <= div_q ? quo_fix : prod_fix[WIDTH-1:0];
    end else if (take) begin
      if (cmd.mt_hi) hi_q <= rs_i;
      if (cmd.mt_lo) lo_q <= rs_i;
    end
  end

  always_comb begin
    if (func_i == F_MFHI)      mf_data_o = hi_q;
    else if (func_i == F_MFLO) mf_data_o = lo_q;
    else                       mf_data_o = '0;
  end

  assign busy_o = busy_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/hilo_mdu_chk.sv
module hilo_mdu_chk
  import mdu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [5:0]       func_i,
  input logic [WIDTH-1:0] rs_i,
  input logic             busy_o,
  input logic [WIDTH-1:0] hi_o,
  input logic [WIDTH-1:0] lo_o
);
  logic is_md, is_mt;
  logic [31:0] bcnt;

  assign is_md = (func_i == F_MULT) || (func_i == F_MULTU) || (func_i == F_DIV) || (func_i == F_DIVU);
  assign is_mt = (func_i == F_MTHI) || (func_i == F_MTLO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bcnt <= '0;
    else if (!busy_o) bcnt <= '0;
    else              bcnt <= bcnt + 1;
  end

  assert_busy_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && is_md |=> busy_o);

  assert_busy_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bcnt < 32'(WIDTH + 1));

  assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> bcnt == 32'(WIDTH + 1));

  assert_mthi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && func_i == F_MTHI |=> hi_o == $past(rs_i) && $stable(lo_o) && !busy_o);

  assert_mtlo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && func_i == F_MTLO |=> lo_o == $past(rs_i) && $stable(hi_o) && !busy_o);

  assert_hold_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o || ($stable(hi_o) && $stable(lo_o)));

  // R9 and R11: move-from and unlisted codes leave state alone
  assert_no_effect_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !is_md && !is_mt |=> $stable(hi_o) && $stable(lo_o) && !busy_o);
endmodule

bind hilo_mdu hilo_mdu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .func_i(func_i),
  .rs_i(rs_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
);

// File: tb/hilo_mdu_bench.sv
module hilo_mdu_bench;
  localparam int BW = 8;
  localparam longint MASK = (longint'(1) << BW) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [5:0] func_i = 6'b0;
  logic [BW-1:0] rs_i = '0, rt_i = '0;
  logic busy_o;
  logic [BW-1:0] hi_o, lo_o, mf_data_o;

  int nchk = 0, nerr = 0;

  always #10 clk_i = ~clk_i;

  hilo_mdu #(.WIDTH(BW)) u_hilo_mdu (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .func_i(func_i),
    .rs_i(rs_i), .rt_i(rt_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o),
    .mf_data_o(mf_data_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [BW-1:0] v);
    return v[BW-1] ? longint'(v) - (longint'(1) << BW) : longint'(v);
  endfunction

  function automatic logic [BW-1:0] pick(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h7f;
      4: return 8'h80;  5: return 8'h81;  6: return 8'hff;  7: return 8'hfe;
      default: return 8'((i * 37 + 11) & 255);
    endcase
  endfunction

  task automatic run_op(input logic [5:0] f, input logic [BW-1:0] a, input logic [BW-1:0] b,
                        input string req);
    int n;
    longint p, q, r, ehi, elo;
    @(negedge clk_i);
    start_i = 1'b1; func_i = f; rs_i = a; rt_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 100) begin n++; @(negedge clk_i); end
    check(n == BW + 1, "R7", n, BW + 1);
    case (f)
      6'b011000: begin p = sx(a) * sx(b); ehi = (p >>> BW) & MASK; elo = p & MASK; end
      6'b011001: begin p = longint'(a) * longint'(b); ehi = (p >> BW) & MASK; elo = p & MASK; end
      6'b011010: begin
        if (b == 0) begin ehi = a; elo = MASK; end
        else begin q = sx(a) / sx(b); r = sx(a) % sx(b); ehi = r & MASK; elo = q & MASK; end
      end
      default: begin
        if (b == 0) begin ehi = a; elo = MASK; end
        else begin ehi = longint'(a) % longint'(b); elo = longint'(a) / longint'(b); end
      end
    endcase
    if (b == 0 && (f == 6'b011010 || f == 6'b011011)) req = "R6";
    check(longint'(hi_o) == ehi, {req, " hi"}, hi_o, ehi);
    check(longint'(lo_o) == elo, {req, " lo"}, lo_o, elo);
  endtask

  task automatic cmd1(input logic [5:0] f, input logic [BW-1:0] a);
    @(negedge clk_i);
    start_i = 1'b1; func_i = f; rs_i = a; rt_i = 8'h00;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nerr++; nchk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [BW-1:0] h0, l0;
    int n;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(hi_o == 0 && lo_o == 0 && !busy_o, "R1", {hi_o, lo_o, 7'b0, busy_o}, 0);
    rst_ni = 1'b1;

    // R2 R3 R4 R5 R6 sweep
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++) begin
        run_op(6'b011000, pick(i), pick(j), "R2");
        run_op(6'b011001, pick(i), pick(j), "R3");
        run_op(6'b011010, pick(i), pick(j), "R4");
        run_op(6'b011011, pick(i), pick(j), "R5");
      end

    // R8 move-to while idle
    cmd1(6'b010001, 8'h3c);
    check(hi_o == 8'h3c && !busy_o, "R8 mthi", hi_o, 8'h3c);
    l0 = lo_o;
    cmd1(6'b010011, 8'hc5);
    check(lo_o == 8'hc5 && hi_o == 8'h3c && !busy_o, "R8 mtlo", {hi_o, lo_o}, 16'h3cc5);
    check(l0 != 8'hc5, "R8 lo changed", l0, 0);

    // R9 move-from reads
    func_i = 6'b010000; #1;
    check(mf_data_o == 8'h3c, "R9 mfhi", mf_data_o, 8'h3c);
    func_i = 6'b010010; #1;
    check(mf_data_o == 8'hc5, "R9 mflo", mf_data_o, 8'hc5);
    func_i = 6'b100000; #1;
    check(mf_data_o == 8'h00, "R9 other", mf_data_o, 0);
    cmd1(6'b010000, 8'h11);
    check(hi_o == 8'h3c && lo_o == 8'hc5 && !busy_o, "R9 no state", {hi_o, lo_o}, 16'h3cc5);

    // R11 unlisted code
    cmd1(6'b100000, 8'h77);
    check(hi_o == 8'h3c && lo_o == 8'hc5 && !busy_o, "R11", {hi_o, lo_o}, 16'h3cc5);

    // R10 commands while busy are ignored
    @(negedge clk_i);
    start_i = 1'b1; func_i = 6'b011001; rs_i = 8'h13; rt_i = 8'h07;
    @(negedge clk_i);
    n = 0;
    func_i = 6'b010001; rs_i = 8'ha5;
    repeat (3) begin
      n++;
      check(hi_o == 8'h3c && busy_o, "R10 hold hi", hi_o, 8'h3c);
      @(negedge clk_i);
    end
    func_i = 6'b010011; rs_i = 8'h5a;
    n++; @(negedge clk_i);
    func_i = 6'b011000; rs_i = 8'hff; rt_i = 8'hff;
    n++; @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o && n < 100) begin n++; @(negedge clk_i); end
    check(n == BW + 1, "R10 busy len", n, BW + 1);
    check(hi_o == 8'h00 && lo_o == 8'h85, "R10 result", {hi_o, lo_o}, 16'h0085);
    cmd1(6'b010001, 8'ha5);
    check(hi_o == 8'ha5 && lo_o == 8'h85, "R10 retry", {hi_o, lo_o}, 16'ha585);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule